// File: doc/BRIEF.md
# Per-Chip DRAM Power Mode Controller

This block decides the power mode of a single memory chip. A memory system places one instance beside each chip, so every chip moves between modes on its own. The controller watches two inputs: a level that says requests are queued for the chip, and a one-cycle strobe for each access. From these it chooses among four modes. In order of falling power they are Active, Standby, Nap and Power-Down. Only Active can serve a read or a write.

Two policies are offered. In the stepping policy, idle time walks the chip down one mode at a time, and each step has its own programmable idle limit. In the two-level policy, the chip rests in one chosen low mode, goes Active while work is queued, and drops back as soon as the queue is empty. Activity seen in any low mode starts a wake-up. The wake-up time depends on the mode being left. For that whole time the ready output is low, and the chip reports Active in the same cycle that ready returns.

Top module: `dram_pwr_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the mode code is 00 (Active) and ready is high. The policy select and the rest mode are sampled from their inputs while reset is high.
- R2: The mode code is 00 Active, 01 Standby, 10 Nap, 11 Power-Down. Under the stepping policy, an Active chip drops to Standby after thr_act_stby_i+1 consecutive cycles with neither an access strobe nor a queued request. Any such activity restarts that count.
- R3: Under the stepping policy, Standby drops to Nap after thr_stby_nap_i+1 idle cycles, and Nap drops to Power-Down after thr_nap_pdn_i+1 idle cycles. Power-Down is held while idle. Each step moves down by exactly one mode.
- R4: An access strobe or a queued request seen in a low mode starts a wake-up. Ready is then low for exactly LAT_STBY, LAT_NAP or LAT_PDN cycles, chosen by the mode being left. During those cycles the mode code keeps the low mode. The code reads 00 in the same cycle that ready returns high.
- R5: Under the two-level policy, an Active chip enters the rest mode in the cycle after it sees neither activity nor a queued request. The chip never steps down while resting. A rest-mode input of 00 means Standby.
- R6: A change of policy select or rest mode is taken only in a cycle where the chip is Active, not waking and has no queued request. Outside such a cycle the change has no effect. The new setting governs behaviour from the next cycle on.
- R7: Activity that arrives during a wake-up does not lengthen or restart it. Activity seen while Active keeps the chip Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| quad_mode_i | input | 1 | Policy select: 1 for stepping, 0 for two-level |
| base_state_i | input | 2 | Rest mode used by the two-level policy |
| thr_act_stby_i | input | THR_W | Idle limit for Active to Standby |
| thr_stby_nap_i | input | THR_W | Idle limit for Standby to Nap |
| thr_nap_pdn_i | input | THR_W | Idle limit for Nap to Power-Down |
| req_pend_i | input | 1 | High while requests are queued for the chip |
| access_i | input | 1 | One-cycle strobe for each access |
| state_o | output | 2 | Current mode code |
| ready_o | output | 1 | Low while a wake-up is in progress |

## Verification
Some properties are checked by the assertions on every cycle. A wake-up drops ready and leaves the mode code unchanged. Ready rises only together with the Active code. A low mode is left only to Active or to the next lower mode. An Active chip that sees activity stays Active. A low-ready stretch never lasts longer than the Power-Down latency.

Other properties depend on exact cycle counts and on history, and only the bench scenarios can show them. These are each dwell count as a function of its threshold, the exact latency for each mode, that activity during a wake-up is ignored, and that a policy change made while the chip rests or has work queued is deferred.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;
  typedef enum logic [1:0] {
    PS_ACT  = 2'b00,
    PS_STBY = 2'b01,
    PS_NAP  = 2'b10,
    PS_PDN  = 2'b11
  } pstate_e;

  // A rest mode of Active makes no sense; map it to Standby.
  function automatic pstate_e rest_of(input logic [1:0] code);
    pstate_e r;
    r = pstate_e'(code);
    if (r == PS_ACT) r = PS_STBY;
    return r;
  endfunction
endpackage

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [THR_W-1:0] thr,
  output logic             expired
);
  logic [THR_W-1:0] cnt_q;

  // Counts idle cycles; saturates so a long rest cannot wrap.
  always_ff @(posedge clk) begin
    if (rst || clr)          cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= thr);
endmodule

// File: rtl/pwr_resume_timer.sv
module pwr_resume_timer
  import dram_pwr_pkg::*;
#(
  parameter int LAT_STBY = 1,
  parameter int LAT_NAP  = 6,
  parameter int LAT_PDN  = 600
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  pstate_e from_st,
  output logic    busy,
  output logic    done
);
  localparam int LAT_MAX = (LAT_PDN > LAT_NAP) ?
                           ((LAT_PDN > LAT_STBY) ? LAT_PDN : LAT_STBY) :
                           ((LAT_NAP > LAT_STBY) ? LAT_NAP : LAT_STBY);
  localparam int CW = (LAT_MAX < 2) ? 1 : $clog2(LAT_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (from_st)
      PS_STBY: load_val = CW'(LAT_STBY - 1);
      PS_NAP:  load_val = CW'(LAT_NAP - 1);
      PS_PDN:  load_val = CW'(LAT_PDN - 1);
      default: load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= load_val;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/pwr_policy.sv
module pwr_policy
  import dram_pwr_pkg::*;
(
  input  pstate_e cur,
  input  logic    quad,
  input  pstate_e rest,
  input  logic    activity,
  input  logic    expired,
  input  logic    busy,
  input  logic    done,
  input  logic    wake,
  output pstate_e nxt
);
  always_comb begin
    nxt = cur;
    if (done) begin
      nxt = PS_ACT;
    end else if (!busy && !wake) begin
      unique case (cur)
        PS_ACT: begin
          if (!activity) begin
            if (!quad)        nxt = rest;
            else if (expired) nxt = PS_STBY;
          end
        end
        PS_STBY: if (quad && expired) nxt = PS_NAP;
        PS_NAP:  if (quad && expired) nxt = PS_PDN;
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/dram_pwr_ctrl.sv
module dram_pwr_ctrl
  import dram_pwr_pkg::*;
#(
  parameter int THR_W    = 16,
  parameter int LAT_STBY = 1,
  parameter int LAT_NAP  = 6,
  parameter int LAT_PDN  = 600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             quad_mode_i,
  input  logic [1:0]       base_state_i,
  input  logic [THR_W-1:0] thr_act_stby_i,
  input  logic [THR_W-1:0] thr_stby_nap_i,
  input  logic [THR_W-1:0] thr_nap_pdn_i,
  input  logic             req_pend_i,
  input  logic             access_i,
  output logic [1:0]       state_o,
  output logic             ready_o
);
  pstate_e          st_q, st_nxt, rest_q;
  logic             quad_q, ready_q;
  logic             activity, wake, busy, done, expired, idle_clr, mode_take;
  logic [THR_W-1:0] thr_cur;

  assign activity  = access_i | req_pend_i;
  assign wake      = (st_q != PS_ACT) && !busy && activity;
  assign mode_take = (st_q == PS_ACT) && !busy && !req_pend_i;

  always_comb begin
    unique case (st_q)
      PS_ACT:  thr_cur = thr_act_stby_i;
      PS_STBY: thr_cur = thr_stby_nap_i;
      default: thr_cur = thr_nap_pdn_i;
    endcase
  end

  assign idle_clr = activity | busy | wake | (st_nxt != st_q);

  pwr_idle_timer #(.THR_W(THR_W)) u_idle (
    .clk(clk), .rst(rst), .clr(idle_clr), .thr(thr_cur), .expired(expired)
  );

  pwr_resume_timer #(.LAT_STBY(LAT_STBY), .LAT_NAP(LAT_NAP), .LAT_PDN(LAT_PDN)) u_resume (
    .clk(clk), .rst(rst), .start(wake), .from_st(st_q), .busy(busy), .done(done)
  );

  pwr_policy u_policy (
    .cur(st_q), .quad(quad_q), .rest(rest_q), .activity(activity),
    .expired(expired), .busy(busy), .done(done), .wake(wake), .nxt(st_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PS_ACT;
      ready_q <= 1'b1;
      quad_q  <= quad_mode_i;
      rest_q  <= rest_of(base_state_i);
    end else begin
      st_q <= st_nxt;
      if (wake)      ready_q <= 1'b0;
      else if (done) ready_q <= 1'b1;
      if (mode_take) begin
        quad_q <= quad_mode_i;
        rest_q <= rest_of(base_state_i);
      end
    end
  end

  assign state_o = st_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/dram_pwr_ctrl_chk.sv
module dram_pwr_ctrl_chk #(
  parameter int LAT_PDN = 600
) (
  input logic       clk,
  input logic       rst,
  input logic       req_pend_i,
  input logic       access_i,
  input logic [1:0] state_o,
  input logic       ready_o
);
  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst)           low_run <= 0;
    else if (!ready_o) low_run <= low_run + 1;
    else               low_run <= 0;
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_READY_LOW_BOUNDED: assert (low_run <= LAT_PDN); // R4
    end
  end

  AST_WAKE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'b00 && ready_o && (access_i || req_pend_i)) |=> (!ready_o && $stable(state_o))); // R4

  AST_READY_RISES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (state_o == 2'b00)); // R4

  AST_RESUME_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> ((state_o == $past(state_o)) || (state_o == 2'b00 && ready_o))); // R7

  AST_STEP_ONE_DOWN: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) != 2'b00 && state_o != $past(state_o)) |->
      (state_o == 2'b00 || (state_o == 2'($past(state_o) + 2'd1) && ready_o))); // R3

  AST_BUSY_STAYS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && ready_o && (access_i || req_pend_i)) |=> (state_o == 2'b00)); // R7

  AST_PDN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b11 && ready_o && !access_i && !req_pend_i) |=> (state_o == 2'b11)); // R3
endmodule

bind dram_pwr_ctrl dram_pwr_ctrl_chk #(.LAT_PDN(LAT_PDN)) u_chk (
  .clk(clk), .rst(rst), .req_pend_i(req_pend_i), .access_i(access_i),
  .state_o(state_o), .ready_o(ready_o)
);

// File: tb/dram_pwr_ctrl_bench.sv
module dram_pwr_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int THR_W      = 16;
  localparam int L_STBY     = 1;
  localparam int L_NAP      = 3;
  localparam int L_PDN      = 7;
  localparam int WDOG       = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             quad_mode_i = 1'b1;
  logic [1:0]       base_state_i = 2'b01;
  logic [THR_W-1:0] thr_as = '0, thr_sn = '0, thr_np = '0;
  logic             req_pend_i = 1'b0;
  logic             access_i = 1'b0;
  logic [1:0]       state_o;
  logic             ready_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  dram_pwr_ctrl #(.THR_W(THR_W), .LAT_STBY(L_STBY), .LAT_NAP(L_NAP), .LAT_PDN(L_PDN)) u_dram_pwr_ctrl (
    .clk(clk), .rst(rst), .quad_mode_i(quad_mode_i), .base_state_i(base_state_i),
    .thr_act_stby_i(thr_as), .thr_stby_nap_i(thr_sn), .thr_nap_pdn_i(thr_np),
    .req_pend_i(req_pend_i), .access_i(access_i), .state_o(state_o), .ready_o(ready_o)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int lat_of(input int s);
    return (s == 1) ? L_STBY : (s == 2) ? L_NAP : L_PDN;
  endfunction

  task automatic do_reset(input bit quad, input int base, input int a, input int s, input int p);
    rst = 1; quad_mode_i = quad; base_state_i = 2'(base);
    thr_as = THR_W'(a); thr_sn = THR_W'(s); thr_np = THR_W'(p);
    access_i = 0; req_pend_i = 0;
    repeat (2) step();
    chk("R1 state in reset", int'(state_o), 0);
    chk("R1 ready in reset", int'(ready_o), 1);
    rst = 0;
  endtask

  task automatic dwell(output int n);
    logic [1:0] prev;
    prev = state_o; n = 0;
    while (state_o == prev && n < 2000) begin step(); n++; end
  endtask

  // Strobe access once, then count the cycles with ready low.
  task automatic wake_and_measure(input bit hold, output int n);
    access_i = 1; step();
    if (!hold) access_i = 0;
    n = 0;
    while (ready_o == 0 && n < 2000) begin n++; step(); end
    access_i = 0;
  endtask

  initial begin
    int n;
    step();
    // R1 + R2 + R3: near-exhaustive sweep of stepping thresholds
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++) begin
          do_reset(1, 1, a, s, p);
          chk("R1 state after reset", int'(state_o), 0);
          dwell(n); chk("R2 active dwell", n, a + 1);
          chk("R2 code standby", int'(state_o), 1);
          dwell(n); chk("R3 standby dwell", n, s + 1);
          chk("R3 code nap", int'(state_o), 2);
          dwell(n); chk("R3 nap dwell", n, p + 1);
          chk("R3 code pdn", int'(state_o), 3);
          repeat (6) step();
          chk("R3 pdn held", int'(state_o), 3);
          // R7: activity during wake ignored (held high through resume)
          wake_and_measure(1, n);
          chk("R4 R7 pdn latency", n, L_PDN);
          chk("R4 active at ready", int'(state_o), 0);
        end

    // R4: latency from each low mode, state code held during resume
    for (int t = 1; t < 4; t++) begin
      do_reset(1, 1, 2, 2, 2);
      n = 0;
      while (int'(state_o) != t && n < 100) begin step(); n++; end
      access_i = 1; step(); access_i = 0;
      chk("R4 ready drops", int'(ready_o), 0);
      chk("R4 code held", int'(state_o), t);
      n = 1;
      while (ready_o == 0 && n < 100) begin step(); if (!ready_o) n++; end
      chk("R4 latency", n, lat_of(t));
      chk("R4 code active", int'(state_o), 0);
    end

    // R2: access restarts the active idle count
    do_reset(1, 1, 5, 0, 0);
    repeat (3) step();
    access_i = 1; step(); access_i = 0;
    chk("R2 still active", int'(state_o), 0);
    dwell(n); chk("R2 dwell after access", n, 6);

    // R5: two-level policy for each rest mode, including code 00
    for (int b = 0; b < 4; b++) begin
      int exp_rest;
      exp_rest = (b == 0) ? 1 : b;
      do_reset(0, b, 0, 0, 0);
      step();
      chk("R5 enters rest", int'(state_o), exp_rest);
      repeat (8) step();
      chk("R5 no stepping", int'(state_o), exp_rest);
      req_pend_i = 1; step();
      chk("R5 wake on pending", int'(ready_o), 0);
      n = 1;
      while (ready_o == 0 && n < 100) begin step(); if (!ready_o) n++; end
      chk("R5 latency", n, lat_of(exp_rest));
      repeat (4) step();
      chk("R7 active while pending", int'(state_o), 0);
      req_pend_i = 0; step();
      chk("R5 back to rest", int'(state_o), exp_rest);
    end

    // R6: policy change while resting is ignored until Active and idle
    do_reset(0, 1, 0, 0, 0);
    step();
    chk("R6 rest standby", int'(state_o), 1);
    quad_mode_i = 1;
    repeat (6) step();
    chk("R6 change ignored while resting", int'(state_o), 1);
    access_i = 1; step(); access_i = 0;
    step();
    chk("R6 woke", int'(state_o), 0);
    step(); chk("R6 old policy at take", int'(state_o), 1);
    step(); chk("R6 new policy nap", int'(state_o), 2);
    step(); chk("R6 new policy pdn", int'(state_o), 3);

    // R6: change with pending request deferred
    do_reset(1, 2, 100, 0, 0);
    req_pend_i = 1; quad_mode_i = 0;
    repeat (5) step();
    chk("R6 active with pending", int'(state_o), 0);
    req_pend_i = 0; step();
    chk("R6 deferred change", int'(state_o), 0);
    step();
    chk("R6 change applied", int'(state_o), 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= WDOG);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule